// File: doc/BRIEF.md
# Prime Bank Address Mapper

This block turns a flat word address into the coordinates of an interleaved vector memory: which bank holds the word, and where the word sits inside that bank. The bank count is a Mersenne prime, 2^M − 1 (seven banks by default). The number of words per bank is a power of two, 2^WORD_BITS. Because the two counts share no factor, strided vector accesses spread across the banks instead of piling onto a few of them. Each address still lands on exactly one bank/slot pair.

The in-bank slot is just the low WORD_BITS of the address. The bank number is the address reduced modulo 2^M − 1, and no divider is used for it. Bit k of the address is worth 2^(k mod M) modulo the bank count. Cutting the address into M-bit chunks therefore gives chunks whose values are already their residues. The chunks are summed with M-bit end-around-carry adders. A final step maps the all-ones sum, which equals the bank count, to zero.

Addresses enter through a valid/ready handshake and pass through two register stages. The first stage holds two partial residues, one for each half of the address. The second stage holds the combined, normalised result. The whole pipeline stalls when a presented result is not taken, so nothing is dropped. When the consumer is always ready, one address is accepted every cycle.

Top module: `prime_bank_mapper`

## Requirements
- R1: `out_bank` equals the accepted address modulo 2^M − 1 (modulo 7 with the default M = 3).
- R2: `out_bank` always lies in 0 .. 2^M − 2. A residue of zero is reported as 0 and never as the all-ones code, including for addresses such as 7, 49 and 0x80000000 + 5.
- R3: `out_word` equals the accepted address modulo 2^WORD_BITS, that is, its low WORD_BITS bits (the low 4 bits by default).
- R4: Over any (2^M − 1)·2^WORD_BITS consecutive addresses (112 by default), no two addresses produce the same (`out_bank`, `out_word`) pair.
- R5: An address accepted on rising edge n is not presented after edge n; it is presented with `out_valid` high after edge n+1. While `out_ready` stays high, `in_ready` stays high and one address is accepted every cycle.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_bank` and `out_word` hold their values.
- R7: After reset, `out_valid` is low and `in_ready` is high. A reset that arrives while results are in flight discards them.
- R8: Results leave in the order their addresses were accepted, for unit-stride, non-unit-stride and random address streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An address is offered |
| in_ready | output | 1 | The mapper takes the offered address on this edge |
| in_addr | input | ADDR_W | Word address to translate |
| out_valid | output | 1 | A translated result is presented |
| out_ready | input | 1 | The consumer takes the presented result |
| out_bank | output | M | Bank number, address mod 2^M − 1 |
| out_word | output | WORD_BITS | Slot inside the bank, address mod 2^WORD_BITS |

## Verification
The hold and stall properties assume the consumer drives `out_ready` from its own state and does not make it depend on `in_valid`. They also assume that inputs change only away from the rising edge. The bench meets both conditions: it drives every input one time step after a rising edge, and it moves `out_ready` only on its own schedule. The latency property assumes reset is held across at least one edge before traffic starts. The bench keeps reset low for several cycles, both at start-up and in the mid-stream reset test.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  // Integer ceiling division for deriving chunk counts from widths.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Number of M-bit chunks that an address of the given width splits into.
  function automatic int chunk_count(input int width, input int m);
    return ceil_div(width, m);
  endfunction

  // Width of the low part of the address folded in the first stage; always a
  // multiple of M so the high part starts on a chunk boundary (weight 2^0).
  function automatic int low_split(input int width, input int m);
    return m * (chunk_count(width, m) / 2);
  endfunction

endpackage

// File: rtl/pbm_fold.sv
// Reduces a bit vector modulo 2^M - 1 by summing its M-bit chunks with
// end-around carry. The result may be the all-ones code, which stands for 0.
module pbm_fold #(
  parameter int M      = 3,
  parameter int N_BITS = 15
) (
  input  logic [N_BITS-1:0] bits_i,
  output logic [M-1:0]      res_o
);
  localparam int NCH   = pbm_pkg::chunk_count(N_BITS, M);
  localparam int PAD_W = NCH * M;

  logic [PAD_W-1:0] padded;
  logic [M-1:0]     chunk [NCH];

  generate
    if (PAD_W > N_BITS) begin : g_pad
      assign padded = {{(PAD_W - N_BITS){1'b0}}, bits_i};
    end else begin : g_nopad
      assign padded = bits_i;
    end
    for (genvar c = 0; c < NCH; c++) begin : g_chunk
      assign chunk[c] = padded[c*M +: M];
    end
  endgenerate

  // One's-complement style addition: the carry out has weight 2^M = 1 mod Nb.
  function automatic logic [M-1:0] eac_add(input logic [M-1:0] a,
                                            input logic [M-1:0] b);
    logic [M:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[M-1:0] + {{(M-1){1'b0}}, s[M]};
  endfunction

  always_comb begin
    res_o = '0;
    for (int c = 0; c < NCH; c++) begin
      res_o = eac_add(res_o, chunk[c]);
    end
  end

endmodule

// File: rtl/pbm_norm.sv
// Maps the redundant all-ones residue (equal to the bank count) back to zero.
module pbm_norm #(
  parameter int M = 3
) (
  input  logic [M-1:0] raw_i,
  output logic [M-1:0] bank_o
);
  logic raw_is_nb;

  assign raw_is_nb = &raw_i;
  assign bank_o    = raw_is_nb ? '0 : raw_i;

endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper #(
  parameter int ADDR_W    = 32,
  parameter int M         = 3,
  parameter int WORD_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [M-1:0]         out_bank,
  output logic [WORD_BITS-1:0] out_word
);
  localparam int LO_W = pbm_pkg::low_split(ADDR_W, M);
  localparam int HI_W = ADDR_W - LO_W;

  // Named pipeline events, used by logic and by the assertions below.
  logic advance;
  logic acc_fire;
  logic s2_load;

  logic [M-1:0]         lo_res, hi_res;
  logic                 s1_valid;
  logic [M-1:0]         s1_lo, s1_hi;
  logic [WORD_BITS-1:0] s1_word;
  logic [M-1:0]         mid_raw, bank_n;

  assign advance  = !(out_valid && !out_ready);
  assign in_ready = advance;
  assign acc_fire = in_valid && advance;
  assign s2_load  = s1_valid && advance;

  // Stage 1: fold each half of the address to a partial residue.
  pbm_fold #(.M(M), .N_BITS(LO_W)) u_fold_lo (
    .bits_i (in_addr[LO_W-1:0]),
    .res_o  (lo_res)
  );

  pbm_fold #(.M(M), .N_BITS(HI_W)) u_fold_hi (
    .bits_i (in_addr[ADDR_W-1:LO_W]),
    .res_o  (hi_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_lo    <= '0;
      s1_hi    <= '0;
      s1_word  <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_lo   <= lo_res;
        s1_hi   <= hi_res;
        s1_word <= in_addr[WORD_BITS-1:0];
      end
    end
  end

  // Stage 2: combine the two partial residues, then normalise.
  pbm_fold #(.M(M), .N_BITS(2*M)) u_fold_mid (
    .bits_i ({s1_hi, s1_lo}),
    .res_o  (mid_raw)
  );

  pbm_norm #(.M(M)) u_norm (
    .raw_i  (mid_raw),
    .bank_o (bank_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bank  <= '0;
      out_word  <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_bank <= bank_n;
        out_word <= s1_word;
      end
    end
  end

  // Bank code never equals the all-ones value (the bank count itself).
  assert_bank_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bank != {M{1'b1}}));

  // An accepted address occupies stage 1 on the next cycle.
  assert_stage1_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> s1_valid);

  // A stage-1 entry moving on is presented on the next cycle.
  assert_stage2_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s2_load |=> out_valid);

  // A refused result stays put.
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bank) && $stable(out_word)));

  // No address is taken while the output is blocked.
  assert_no_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/prime_bank_mapper_tb.sv
module prime_bank_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 7;
  localparam int NW = 16;
  localparam int NT = 10;

  localparam logic [31:0] T_ADDR [NT] = '{
    32'h0000_0000, 32'h0000_0006, 32'h0000_0007, 32'h0000_0008, 32'hFFFF_FFFF,
    32'h1234_5678, 32'h8000_0000, 32'h0000_0031, 32'h0000_0064, 32'hDEAD_BEEF};
  localparam int T_BANK [NT] = '{0, 6, 0, 1, 3, 5, 2, 0, 2, 6};
  localparam int T_WORD [NT] = '{0, 6, 7, 8, 15, 8, 0, 1, 4, 15};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_bank;
  logic [3:0]  out_word;

  int n_checks = 0;
  int n_fail = 0;

  int exp_bank_q[$];
  int exp_word_q[$];
  bit use_table = 1'b0;
  int tbl_idx = 0;
  bit uniq_mode = 1'b0;
  bit seen [NB*NW];
  int dup_cnt = 0;
  int uniq_cnt = 0;
  bit count_stalls = 1'b0;
  int stall_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prime_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_bank(out_bank), .out_word(out_word)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_bank(input logic [31:0] a);
    return int'({32'd0, a} % 64'd7);
  endfunction

  // Monitor: compare presented results, then record newly accepted addresses.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_bank_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", out_bank, -1);
        end else begin
          int eb, ew;
          eb = exp_bank_q.pop_front();
          ew = exp_word_q.pop_front();
          check(out_bank == eb, "R1/R8 bank", out_bank, eb);
          check(out_word == ew, "R3/R8 word", out_word, ew);
          check(out_bank < NB, "R2 bank range", out_bank, NB - 1);
          if (uniq_mode) begin
            if (seen[out_bank*NW + out_word]) dup_cnt++;
            seen[out_bank*NW + out_word] = 1'b1;
            uniq_cnt++;
          end
        end
      end
      if (count_stalls && in_valid && !in_ready) stall_cnt++;
      if (in_valid && in_ready) begin
        if (use_table) begin
          exp_bank_q.push_back(T_BANK[tbl_idx]);
          exp_word_q.push_back(T_WORD[tbl_idx]);
          tbl_idx++;
        end else begin
          exp_bank_q.push_back(ref_bank(in_addr));
          exp_word_q.push_back(int'(in_addr[3:0]));
        end
      end
    end
  end

  // Called one step after a rising edge; returns one step after the accepting edge.
  task automatic send(input logic [31:0] a);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  task automatic drain();
    idle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R7: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R7 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // R1/R2/R3: table walk, streamed back to back; R5 throughput
    use_table = 1'b1;
    count_stalls = 1'b1;
    for (int k = 0; k < NT; k++) send(T_ADDR[k]);
    count_stalls = 1'b0;
    drain();
    use_table = 1'b0;
    check(stall_cnt == 0, "R5 throughput stalls", stall_cnt, 0);
    check(exp_bank_q.size() == 0, "R8 all table results seen", exp_bank_q.size(), 0);

    // R5: latency of a single address
    send(32'h0000_002A);
    idle();
    @(negedge clk);
    check(out_valid == 1'b0, "R5 not presented after accept edge", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5 presented after next edge", out_valid, 1);
    check(out_bank == 3'd0, "R5/R2 bank of 42", out_bank, 0);
    drain();

    // R4: uniqueness over 112 consecutive addresses
    uniq_mode = 1'b1;
    for (int a = 0; a < NB*NW; a++) send(32'h0000_4000 + a);
    drain();
    uniq_mode = 1'b0;
    check(uniq_cnt == NB*NW, "R4 result count", uniq_cnt, NB*NW);
    check(dup_cnt == 0, "R4 duplicate pairs", dup_cnt, 0);

    // R8: strided streams (stride 8 and stride 7) and random addresses
    for (int k = 0; k < 64; k++) send(32'h0001_0000 + 32'(k*8));
    for (int k = 0; k < 40; k++) send(32'h0002_0003 + 32'(k*7));
    for (int k = 0; k < 200; k++) send($urandom);
    drain();
    check(exp_bank_q.size() == 0, "R8 all stream results seen", exp_bank_q.size(), 0);

    // R6: backpressure
    out_ready = 1'b0;
    send(32'h0000_0064);
    send(32'h0000_0065);
    in_valid = 1'b1;
    in_addr  = 32'h0000_0066;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6 out_valid held", out_valid, 1);
      check(in_ready == 1'b0, "R6 in_ready low", in_ready, 0);
      check(out_bank == 3'd2, "R6 bank held", out_bank, 2);
      check(out_word == 4'd4, "R6 word held", out_word, 4);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    drain();
    check(exp_bank_q.size() == 0, "R6 queue drained", exp_bank_q.size(), 0);

    // R7: reset with results in flight
    send(32'h0000_0011);
    idle();
    rst_n = 1'b0;
    exp_bank_q.delete();
    exp_word_q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 in-flight discarded", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 nothing after reset", out_valid, 0);
    check(in_ready == 1'b1, "R7 ready after reset", in_ready, 1);

    finish_run();
  end

endmodule